// File: doc/BRIEF.md
# Flash Erase Status Bit Generator

This block models, on the device side, the status byte that a sector-erase flash returns while an embedded erase runs. It keeps a mask of the sectors chosen for erasure, plus the current operating mode. Each status read returns a byte with two toggle bits. Bit 6 flips on every read while the erase is actively running, so it tells the host the mode. Bit 2 flips only on reads that land in a chosen sector, so it tells the host which sectors are chosen. Bit 5 reports that the operation ran past its limit.

A command decoder outside this block sends a one-cycle start event when the last write strobe of an erase command rises. With it comes the sector mask. The decoder also sends suspend, resume and completion pulses, and a failure pulse when the operation times out. Outside an embedded operation, a read returns the stored array byte given on an input port. The sector is taken from the top three bits of the read address, so eight sectors are supported.

The mode machine has four states. IDLE means no operation is running. ERASING means the erase is active. SUSPENDED means the erase is paused. FAILED means the limit was exceeded. The transitions are:
- START: IDLE to ERASING, on the start event.
- PAUSE: ERASING to SUSPENDED, on suspend.
- RESUME: SUSPENDED to ERASING, on resume.
- TIMEOUT: ERASING to FAILED, on fail.
- COMPLETE: ERASING or FAILED to IDLE, on done.

Top module: `erase_status_gen`

## Requirements
- R1: While reset is held and after it is released, `status_out` is 0x00, the state is IDLE and the sector mask is clear.
- R2: Every read updates `status_out` one cycle after the strobe, and `status_out` holds its value on cycles with no read. In IDLE a read returns `array_data`.
- R3: A start event in IDLE (transition START) loads `erase_sel` as the sector mask, sets both toggle bits to 0 and enters ERASING. A start event in any other state is ignored and leaves the mask unchanged.
- R4: In ERASING every read returns a status byte, and bit 6 inverts after each one. The first read after START shows bit 6 = 0.
- R5: Bit 2 inverts after each status read whose sector (address bits [15:13]) is set in the mask. A read of an unselected sector leaves bit 2 as it is and reports its held value.
- R6: Suspend in ERASING enters SUSPENDED (PAUSE). There, bit 6 neither changes nor inverts. Reads of selected sectors return status and still invert bit 2, and reads of unselected sectors return `array_data`. Resume returns to ERASING (RESUME).
- R7: Fail in ERASING enters FAILED (TIMEOUT). There, status bytes carry bit 5 = 1, bit 6 stops inverting, and bit 2 still inverts on reads of selected sectors. In every other state bit 5 is 0.
- R8: Done in ERASING or FAILED (COMPLETE) returns to IDLE and clears the mask. Done takes priority over fail, and fail takes priority over suspend, when they arrive together. Suspend, resume and done are ignored in states that have no transition for them.
- R9: In every status byte, bits 7, 4, 3, 1 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Pulse when the last write strobe of an erase command rises |
| erase_sel | input | 8 | Sector mask sampled on an accepted start |
| cmd_suspend | input | 1 | Suspend request pulse |
| cmd_resume | input | 1 | Resume request pulse |
| op_fail | input | 1 | Operation exceeded its limit |
| op_done | input | 1 | Erase finished or was abandoned |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | 16 | Read address; bits [15:13] give the sector |
| array_data | input | 8 | Stored array byte for non-status reads |
| status_out | output | 8 | Byte returned by the last read |

## Verification
A stuck or wrongly advanced mode register shows up at the first read that follows it. Bit 6 either fails to flip between two reads in ERASING, or flips during SUSPENDED or FAILED. In either case the byte on the next cycle is wrong. A corrupted mask entry shows up only when that sector is read: bit 2 flips where it should hold (or the other way round), or a read during suspend returns array data instead of status. The bench therefore reads every sector in every mode, and compares `status_out` against its reference model on each clock.

// File: rtl/erase_status_pkg.sv
package erase_status_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_SUSP  = 2'd2,
        ST_FAIL  = 2'd3
    } erase_mode_e;

    localparam int MODE_TGL_BIT = 6;
    localparam int SECT_TGL_BIT = 2;
    localparam int TIMEOUT_BIT  = 5;
endpackage

// File: rtl/erase_mode_fsm.sv
module erase_mode_fsm
    import erase_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_evt,
    input  logic        suspend_evt,
    input  logic        resume_evt,
    input  logic        fail_evt,
    input  logic        done_evt,
    output erase_mode_e mode_q,
    output logic        load_en,
    output logic        clear_en
);
    erase_mode_e mode_d;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ST_IDLE;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_IDLE:  if (start_evt) mode_d = ST_ERASE;
            ST_ERASE: begin
                if (done_evt)         mode_d = ST_IDLE;
                else if (fail_evt)    mode_d = ST_FAIL;
                else if (suspend_evt) mode_d = ST_SUSP;
            end
            ST_SUSP:  if (resume_evt) mode_d = ST_ERASE;
            ST_FAIL:  if (done_evt)   mode_d = ST_IDLE;
            default:  mode_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en  = (mode_q == ST_IDLE) && start_evt;
        clear_en = ((mode_q == ST_ERASE) || (mode_q == ST_FAIL)) && done_evt;
    end
endmodule

// File: rtl/erase_sector_mask.sv
module erase_sector_mask #(
    parameter int NSECT = 8,
    parameter int SEC_W = $clog2(NSECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [NSECT-1:0] load_val,
    input  logic [SEC_W-1:0] sect_idx,
    output logic [NSECT-1:0] mask_q,
    output logic             hit
);
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (clear) mask_q <= '0;
        else if (load)  mask_q <= load_val;
    end

    assign hit = mask_q[sect_idx];
endmodule

// File: rtl/toggle_bank.sv
module toggle_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] flip,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_tgl
        always_ff @(posedge clk) begin
            if (!rst_n)       q[i] <= 1'b0;
            else if (clr)     q[i] <= 1'b0;
            else if (flip[i]) q[i] <= ~q[i];
        end
    end
endmodule

// File: rtl/erase_status_gen.sv
module erase_status_gen
    import erase_status_pkg::*;
#(
    parameter int NSECT  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [NSECT-1:0]  erase_sel,
    input  logic              cmd_suspend,
    input  logic              cmd_resume,
    input  logic              op_fail,
    input  logic              op_done,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] status_out
);
    localparam int SEC_W = $clog2(NSECT);
    localparam int LO_W  = ADDR_W - SEC_W;

    erase_mode_e      mode_q;
    logic             load_en, clear_en, sec_hit, read_status;
    logic [NSECT-1:0] sel_mask_q;
    logic [SEC_W-1:0] sect_idx;
    logic [1:0]       tgl_q, tgl_flip;
    logic [DATA_W-1:0] status_w;
    logic             unused_lo;

    assign sect_idx  = rd_addr[ADDR_W-1 -: SEC_W];
    assign unused_lo = ^rd_addr[LO_W-1:0];

    erase_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_evt(cmd_start), .suspend_evt(cmd_suspend),
        .resume_evt(cmd_resume), .fail_evt(op_fail), .done_evt(op_done),
        .mode_q(mode_q), .load_en(load_en), .clear_en(clear_en)
    );

    erase_sector_mask #(.NSECT(NSECT)) u_mask (
        .clk(clk), .rst_n(rst_n), .load(load_en), .clear(clear_en),
        .load_val(erase_sel), .sect_idx(sect_idx),
        .mask_q(sel_mask_q), .hit(sec_hit)
    );

    // bit 1: mode toggle, bit 0: sector toggle
    toggle_bank #(.N(2)) u_tgl (
        .clk(clk), .rst_n(rst_n), .clr(load_en),
        .flip(tgl_flip), .q(tgl_q)
    );

    always_comb begin
        read_status = rd_stb && ((mode_q == ST_ERASE) || (mode_q == ST_FAIL)
                                 || ((mode_q == ST_SUSP) && sec_hit));
        tgl_flip[1] = rd_stb && (mode_q == ST_ERASE);
        tgl_flip[0] = read_status && sec_hit;
        status_w               = '0;
        status_w[MODE_TGL_BIT] = tgl_q[1];
        status_w[SECT_TGL_BIT] = tgl_q[0];
        status_w[TIMEOUT_BIT]  = (mode_q == ST_FAIL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           status_out <= '0;
        else if (read_status) status_out <= status_w;
        else if (rd_stb)      status_out <= array_data;
    end
endmodule

// File: rtl/erase_status_chk.sv
module erase_status_chk
    import erase_status_pkg::*;
#(
    parameter int NSECT  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              op_done,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] status_out,
    input erase_mode_e       mode_q,
    input logic [NSECT-1:0]  sel_mask_q,
    input logic              sec_hit
);
    logic prev_erase_rd;

    always_ff @(posedge clk) begin
        if (!rst_n)                prev_erase_rd <= 1'b0;
        else if (rd_stb)           prev_erase_rd <= (mode_q == ST_ERASE);
        else if (mode_q != ST_ERASE) prev_erase_rd <= 1'b0;
    end

    // R2
    hold_when_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(status_out));

    // R2
    idle_read_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode_q == ST_IDLE) |=> (status_out == $past(array_data)));

    // R4
    mode_toggle_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode_q == ST_ERASE && prev_erase_rd)
        |=> (status_out[MODE_TGL_BIT] != $past(status_out[MODE_TGL_BIT])));

    // R7
    timeout_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode_q == ST_FAIL) |=> status_out[TIMEOUT_BIT]);

    // R8
    mask_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && (mode_q == ST_ERASE || mode_q == ST_FAIL))
        |=> (sel_mask_q == '0 && mode_q == ST_IDLE));

    // R9
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (mode_q == ST_ERASE || mode_q == ST_FAIL
                    || (mode_q == ST_SUSP && sec_hit)))
        |=> (status_out[7] == 1'b0 && status_out[4:3] == 2'b00
             && status_out[1:0] == 2'b00));
endmodule

bind erase_status_gen erase_status_chk #(.NSECT(NSECT), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .op_done(op_done),
    .array_data(array_data), .status_out(status_out),
    .mode_q(mode_q), .sel_mask_q(sel_mask_q), .sec_hit(sec_hit)
);

// File: tb/tb_erase_status_gen.sv
module tb_erase_status_gen;
    logic        clk = 0, rst_n = 0;
    logic        cmd_start = 0, cmd_suspend = 0, cmd_resume = 0;
    logic        op_fail = 0, op_done = 0, rd_stb = 0;
    logic [7:0]  erase_sel = 0, array_data = 0;
    logic [15:0] rd_addr = 0;
    logic [7:0]  status_out;

    int    errors = 0, checks = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // reference model: mode 0 idle, 1 erase, 2 suspend, 3 fail
    int       m_mode;
    bit [7:0] m_mask, m_out;
    bit       m_t6, m_t2;

    always #5 clk = ~clk;

    erase_status_gen dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .erase_sel(erase_sel),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .op_fail(op_fail),
        .op_done(op_done), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .array_data(array_data), .status_out(status_out)
    );

    function automatic bit [7:0] stat_byte(bit t6, bit f, bit t2);
        return {1'b0, t6, f, 2'b00, t2, 2'b00};
    endfunction

    always @(posedge clk) begin
        bit sel;
        if (!rst_n) begin
            m_mode = 0; m_mask = 0; m_out = 0; m_t6 = 0; m_t2 = 0;
        end else begin
            sel = m_mask[rd_addr[15:13]];
            if (rd_stb) begin
                if (m_mode == 0 || (m_mode == 2 && !sel)) m_out = array_data;
                else begin
                    m_out = stat_byte(m_t6, m_mode == 3, m_t2);
                    if (m_mode == 1) m_t6 = !m_t6;
                    if (sel) m_t2 = !m_t2;
                end
            end
            if (m_mode == 0 && cmd_start) begin
                m_mode = 1; m_mask = erase_sel; m_t6 = 0; m_t2 = 0;
            end else if ((m_mode == 1 || m_mode == 3) && op_done) begin
                m_mode = 0; m_mask = 0;
            end else if (m_mode == 1 && op_fail) m_mode = 3;
            else if (m_mode == 1 && cmd_suspend) m_mode = 2;
            else if (m_mode == 2 && cmd_resume) m_mode = 1;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: status_out=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !finished) chk(cur_req, status_out, m_out);

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(int sec, logic [7:0] d);
        rd_addr = {sec[2:0], 13'h0a5}; array_data = d; rd_stb = 1;
        step(1);
        rd_stb = 0; array_data = ~d;
    endtask

    task automatic pulse_start(logic [7:0] m);
        erase_sel = m; cmd_start = 1; step(1); cmd_start = 0; erase_sel = 8'hff;
    endtask

    initial begin
        step(3);
        chk("R1", status_out, 8'h00);
        rst_n = 1;
        step(1);
        chk("R1", status_out, 8'h00);

        cur_req = "R2";
        rd(0, 8'h3c); rd(5, 8'hc3); step(3); rd(7, 8'h81);
        @(negedge clk); chk("R2", status_out, 8'h81);
        step(2);

        cur_req = "R3";
        pulse_start(8'b0010_0101);          // sectors 0, 2, 5
        cur_req = "R4";
        rd(0, 8'h11);
        @(negedge clk); chk("R4", status_out, 8'h00);
        step(1);
        rd(1, 8'h22);
        @(negedge clk); chk("R5", status_out, 8'h44);
        step(1);
        cur_req = "R5";
        rd(2, 8'h33); rd(7, 8'h44); rd(5, 8'h55); step(2); rd(3, 8'h66);
        cur_req = "R3";
        pulse_start(8'b0000_0010);          // ignored: sector 1 stays unselected
        rd(1, 8'h77); rd(1, 8'h78);
        cur_req = "R9";
        rd(0, 8'hff); rd(4, 8'hff);

        cur_req = "R6";
        cmd_suspend = 1; step(1); cmd_suspend = 0;
        rd(0, 8'h9a); rd(1, 8'h9b); rd(2, 8'h9c); rd(6, 8'h9d); rd(5, 8'h9e);
        cur_req = "R8";
        op_done = 1; step(1); op_done = 0;  // ignored in suspend
        rd(5, 8'h01);
        cur_req = "R6";
        cmd_resume = 1; step(1); cmd_resume = 0;
        rd(0, 8'h02); rd(1, 8'h03); rd(2, 8'h04);

        cur_req = "R8";
        op_done = 1; op_fail = 1; cmd_suspend = 1; step(1);
        op_done = 0; op_fail = 0; cmd_suspend = 0;
        rd(0, 8'h5a); rd(2, 8'ha5);
        @(negedge clk); chk("R8", status_out, 8'ha5);
        step(1);

        cur_req = "R7";
        pulse_start(8'b1100_0000);          // sectors 6, 7
        rd(6, 8'h10); rd(7, 8'h20);
        op_fail = 1; cmd_suspend = 1; step(1); op_fail = 0; cmd_suspend = 0;
        rd(6, 8'h30); rd(0, 8'h40); rd(7, 8'h50);
        cmd_suspend = 1; step(1); cmd_suspend = 0;
        rd(6, 8'h60);
        cur_req = "R8";
        op_done = 1; step(1); op_done = 0;
        rd(6, 8'h70); rd(7, 8'h71);
        cur_req = "R7";
        pulse_start(8'b0000_0001);
        rd(0, 8'h00); rd(0, 8'h00);
        cur_req = "R8";
        op_done = 1; rd(0, 8'h0f); op_done = 0;
        rd(0, 8'h0e);
        step(3);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule